// File: doc/BRIEF.md
# Audio Configuration Register File with Two-Wire Serial Slave

This block is the control port of an audio amplifier datapath. An external controller writes and reads a handful of configuration registers over a two-wire serial bus (I2C, standard mode, slave only). The block samples the clock and data lines on its own system clock, cleans them through synchronisers and a glitch filter, decodes start, stop, address, data and acknowledge phases, and pulls the data line low through an output enable only. It never drives or holds the clock line.

The register contents leave the block as decoded fields: serial input format, sample-rate group, master-clock ratio, per-channel gain, per-channel audible and halt controls, noise-shaper order, modulation depth and idle-pulse enable. A status register records the most recent register address that was accessed. A soft-reset code restores all registers. When the active-low reset is released, the block latches whether the bus lines were both held low. This selects pin-only operation, which the datapath uses to ignore the register values.

Top module: `audio_cfg_i2c_slave`

## Requirements
- R1: The slave answers only to the 7-bit address 1101100 with R/W bit 0 = write, 1 = read. For any other address it leaves SDA released (no ACK) and changes no register.
- R2: A write transfer (address byte, register address byte, one data byte) is acknowledged on each byte and updates the register. The fields appear at the ports: 10h gives fmt_sel = bits 2:0, srate_sel = bits 4:3, mclk_ratio = bits 6:5. 20h (left) and 21h (right) give gain = bits 5:0, on = bit 6, halt = bit 7. 30h gives idle_pulse = bit 1, mod_full = bit 2, ns_high_order = bit 3.
- R3: A random read is a write of the register address, then a repeated start, then the read address byte. It returns the register MSB first. 10h reads bit 7 as 0. 30h reads bits 7:4 as 0 and bit 0 as 1.
- R4: After reset the registers read 10h = 08h, 20h = 00h, 21h = 00h and 30h = 03h, and the ports show the matching fields.
- R5: Register 00h returns the register address of the most recent data write or read. Data written to 00h is discarded, but the access itself is recorded.
- R6: Writing data FFh to address FFh returns every register, including 00h, to its reset value. Any other data written to FFh does nothing, and a read of FFh returns 00h.
- R7: A write to an undefined address is acknowledged and has no effect. A read from an undefined address returns 00h.
- R8: When reset is released with SCL and SDA both low, pin_only_mode is 1; otherwise it is 0. The value then holds until the next reset.
- R9: sda_oe changes only while the filtered SCL is low, and there is no SCL output.
- R10: A pulse on SCL shorter than FILT_LEN system clocks is ignored and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pin_only_mode | output | 1 | Operating mode latched at reset release |
| fmt_sel | output | 3 | Serial audio input format code |
| srate_sel | output | 2 | Sample-rate group |
| mclk_ratio | output | 2 | Master-clock ratio code |
| left_gain | output | 6 | Left channel gain step |
| left_on | output | 1 | Left channel audible (0 = muted) |
| left_halt | output | 1 | Left channel PWM stopped |
| right_gain | output | 6 | Right channel gain step |
| right_on | output | 1 | Right channel audible (0 = muted) |
| right_halt | output | 1 | Right channel PWM stopped |
| ns_high_order | output | 1 | Higher noise-shaper order selected |
| mod_full | output | 1 | Full modulation depth selected |
| idle_pulse | output | 1 | 50 % pulse while muted |

## Verification
A wrong protocol state shows up within one SCL period. The ACK slot is missing or comes at the wrong place, or the read data is shifted by a bit. All of these are seen at sda_oe on the same byte. A wrong register state shows up on the field ports one system clock after the data byte's eighth bit is taken, and a read-back confirms it. The last-address and mode latches only show up on a later read or after a reset, so the bench places a read, or a second reset, directly after the access that sets them.

// File: rtl/acfg_pkg.sv
package acfg_pkg;
    typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_RACK} phase_e;
    typedef enum logic [1:0] {BY_DEV, BY_SUB, BY_DATA} byte_e;

    localparam logic [7:0] ADR_LAST = 8'h00;
    localparam logic [7:0] ADR_FMT  = 8'h10;
    localparam logic [7:0] ADR_LCH  = 8'h20;
    localparam logic [7:0] ADR_RCH  = 8'h21;
    localparam logic [7:0] ADR_MISC = 8'h30;
    localparam logic [7:0] ADR_SRST = 8'hFF;
endpackage

// File: rtl/acfg_line_filter.sv
module acfg_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   out;
    } flt_t;

    flt_t q, d;
    logic synced;

    assign synced = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], raw};
        if (synced == q.out) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_LEN - 1)) begin
            d.out = synced;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sync: '1, cnt: '0, out: 1'b1};
        else        q <= d;
    end

    assign clean = q.out;
endmodule

// File: rtl/acfg_bus_engine.sv
module acfg_bus_engine
    import acfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       scl,
    input  logic       sda,
    input  logic [7:0] rd_data,
    output logic       wr_en,
    output logic       rd_en,
    output logic [7:0] reg_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    typedef struct packed {
        phase_e     ph;
        byte_e      by;
        logic [3:0] bits;
        logic [7:0] sh;
        logic       rw;
        logic [7:0] ptr;
        logic       oe;
        logic       scl_p;
        logic       sda_p;
        logic       wr;
        logic [7:0] wdat;
        logic       rd;
    } eng_t;

    eng_t q, d;
    logic rise, fall, start, stop;

    assign rise  = scl & ~q.scl_p;
    assign fall  = ~scl & q.scl_p;
    assign start = q.scl_p & scl & q.sda_p & ~sda;
    assign stop  = q.scl_p & scl & ~q.sda_p & sda;

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        d.rd    = 1'b0;
        d.scl_p = scl;
        d.sda_p = sda;
        if (!en) begin
            d.ph = PH_IDLE;
            d.oe = 1'b0;
        end else if (start) begin
            d.ph   = PH_RX;
            d.by   = BY_DEV;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (stop) begin
            d.ph = PH_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.ph)
                PH_RX: begin
                    if (rise) begin
                        d.sh   = {q.sh[6:0], sda};
                        d.bits = q.bits + 1'b1;
                    end else if (fall && q.bits == 4'd8) begin
                        d.ph = PH_ACK;
                        d.oe = 1'b1;
                        unique case (q.by)
                            BY_DEV: begin
                                d.rw = q.sh[0];
                                if (q.sh[7:1] != DEV_ADDR) begin
                                    d.ph = PH_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            BY_SUB:  d.ptr = q.sh;
                            default: begin
                                d.wr   = 1'b1;
                                d.wdat = q.sh;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (fall) begin
                        d.bits = '0;
                        if (q.by == BY_DEV && q.rw) begin
                            d.ph = PH_TX;
                            d.sh = rd_data;
                            d.rd = 1'b1;
                            d.oe = ~rd_data[7];
                        end else begin
                            d.ph = PH_RX;
                            d.oe = 1'b0;
                            d.by = (q.by == BY_DEV) ? BY_SUB : BY_DATA;
                        end
                    end
                end
                PH_TX: begin
                    if (fall) begin
                        if (q.bits == 4'd7) begin
                            d.ph = PH_RACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.oe   = ~q.sh[6];
                            d.bits = q.bits + 1'b1;
                        end
                    end
                end
                PH_RACK: begin
                    if (rise) begin
                        d.sh[0] = sda;
                    end else if (fall) begin
                        if (q.sh[0]) begin
                            d.ph = PH_IDLE;
                        end else begin
                            d.ph   = PH_TX;
                            d.sh   = rd_data;
                            d.rd   = 1'b1;
                            d.oe   = ~rd_data[7];
                            d.bits = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
            q.by    <= BY_DEV;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wr_en    = q.wr;
    assign wr_data  = q.wdat;
    assign rd_en    = d.rd;
    assign reg_addr = q.ptr;
    assign sda_oe   = q.oe;

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl) |-> $stable(q.oe))
        else $error("sda_oe moved while SCL high");
endmodule

// File: rtl/acfg_regfile.sv
module acfg_regfile
    import acfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [6:0] fmt_word,
    output logic [7:0] lch_word,
    output logic [7:0] rch_word,
    output logic [2:0] misc_word
);
    typedef struct packed {
        logic [6:0] fmt;
        logic [7:0] lch;
        logic [7:0] rch;
        logic [2:0] misc;
        logic [7:0] last;
    } rf_t;

    localparam rf_t RF_INIT = '{fmt: 7'b00_01_000, lch: 8'h00, rch: 8'h00,
                                misc: 3'b001, last: 8'h00};

    rf_t q, d;

    always_comb begin
        d = q;
        if (rd_en) d.last = addr;
        if (wr_en) begin
            d.last = addr;
            case (addr)
                ADR_FMT:  d.fmt  = wr_data[6:0];
                ADR_LCH:  d.lch  = wr_data;
                ADR_RCH:  d.rch  = wr_data;
                ADR_MISC: d.misc = wr_data[3:1];
                ADR_SRST: if (wr_data == 8'hFF) d = RF_INIT;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RF_INIT;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            ADR_LAST: rd_data = q.last;
            ADR_FMT:  rd_data = {1'b0, q.fmt};
            ADR_LCH:  rd_data = q.lch;
            ADR_RCH:  rd_data = q.rch;
            ADR_MISC: rd_data = {4'b0000, q.misc, 1'b1};
            default:  rd_data = 8'h00;
        endcase
    end

    assign fmt_word  = q.fmt;
    assign lch_word  = q.lch;
    assign rch_word  = q.rch;
    assign misc_word = q.misc;

    // R5
    last_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_LAST) |=> (q.fmt == $past(q.fmt) && q.lch == $past(q.lch)
                                         && q.rch == $past(q.rch) && q.misc == $past(q.misc)))
        else $error("write to status register changed configuration");

    // R6
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_SRST && wr_data == 8'hFF) |=>
            (q.lch == 8'h00 && q.rch == 8'h00 && q.misc == 3'b001 && q.last == 8'h00))
        else $error("soft reset left a register set");
endmodule

// File: rtl/audio_cfg_i2c_slave.sv
module audio_cfg_i2c_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b1101100,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       pin_only_mode,
    output logic [2:0] fmt_sel,
    output logic [1:0] srate_sel,
    output logic [1:0] mclk_ratio,
    output logic [5:0] left_gain,
    output logic       left_on,
    output logic       left_halt,
    output logic [5:0] right_gain,
    output logic       right_on,
    output logic       right_halt,
    output logic       ns_high_order,
    output logic       mod_full,
    output logic       idle_pulse
);
    localparam int SETTLE = SYNC_STAGES + FILT_LEN + 3;
    localparam int SW     = $clog2(SETTLE + 1);

    logic [1:0] raw_lines, clean_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        acfg_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_flt (
            .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .clean(clean_lines[g]));
    end

    typedef struct packed {
        logic [SW-1:0] cnt;
        logic          settled;
        logic          pin_mode;
    } top_t;

    top_t q, d;

    always_comb begin
        d = q;
        if (!q.settled) begin
            if (q.cnt == SW'(SETTLE - 1)) begin
                d.settled  = 1'b1;
                d.pin_mode = ~clean_lines[0] & ~clean_lines[1];
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic       wr_en, rd_en;
    logic [7:0] reg_addr, wr_data, rd_data, lch, rch;
    logic [6:0] fmt;
    logic [2:0] misc;

    acfg_bus_engine #(.DEV_ADDR(DEV_ADDR)) i_eng (
        .clk(clk), .rst_n(rst_n), .en(q.settled),
        .scl(clean_lines[0]), .sda(clean_lines[1]), .rd_data(rd_data),
        .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr), .wr_data(wr_data),
        .sda_oe(sda_oe));

    acfg_regfile i_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .fmt_word(fmt), .lch_word(lch),
        .rch_word(rch), .misc_word(misc));

    assign pin_only_mode = q.pin_mode;
    assign fmt_sel       = fmt[2:0];
    assign srate_sel     = fmt[4:3];
    assign mclk_ratio    = fmt[6:5];
    assign left_gain     = lch[5:0];
    assign left_on       = lch[6];
    assign left_halt     = lch[7];
    assign right_gain    = rch[5:0];
    assign right_on      = rch[6];
    assign right_halt    = rch[7];
    assign idle_pulse    = misc[0];
    assign mod_full      = misc[1];
    assign ns_high_order = misc[2];

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.settled && $past(q.settled)) |-> $stable(q.pin_mode))
        else $error("mode latch changed after settling");
endmodule

// File: tb/test_audio_cfg_i2c_slave.sv
`timescale 1ns/1ps
module test_audio_cfg_i2c_slave;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'b1101100;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, pin_only_mode, left_on, left_halt, right_on, right_halt;
    logic ns_high_order, mod_full, idle_pulse, sda_line;
    logic [2:0] fmt_sel;
    logic [1:0] srate_sel, mclk_ratio;
    logic [5:0] left_gain, right_gain;
    int checks = 0, bad = 0, viol = 0;
    bit done = 0;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    audio_cfg_i2c_slave i_audio_cfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .pin_only_mode(pin_only_mode), .fmt_sel(fmt_sel), .srate_sel(srate_sel),
        .mclk_ratio(mclk_ratio), .left_gain(left_gain), .left_on(left_on),
        .left_halt(left_halt), .right_gain(right_gain), .right_on(right_on),
        .right_halt(right_halt), .ns_high_order(ns_high_order), .mod_full(mod_full),
        .idle_pulse(idle_pulse));

    // R9 monitor: sda_oe may only move while raw SCL is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_m) viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq();
            if (glitch && i == 4) begin
                @(negedge clk) scl_m = 1'b0;
                @(negedge clk) scl_m = 1'b1;
                repeat (Q - 2) @(negedge clk);
            end else begin
                wq();
            end
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl_m = 1'b0; wq();
        end
        sda_m = nack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] v, input bit glitch,
                             output bit all_ack);
        bit a0, a1, a2;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, a0);
        send_byte(a, 1'b0, a1);
        send_byte(v, glitch, a2);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] v);
        bit ak;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ak);
        send_byte(a, 1'b0, ak);
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, ak);
        recv_byte(1'b1, v);
        bus_stop();
    endtask

    task automatic do_reset(input logic lines);
        scl_m = lines; sda_m = lines; rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        scl_m = 1'b1; @(negedge clk); sda_m = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset(1'b1);
        chk(pin_only_mode == 1'b0, "R8 combined mode", pin_only_mode, 0);
        chk({mclk_ratio, srate_sel, fmt_sel} == 7'b00_01_000, "R4 format fields",
            {mclk_ratio, srate_sel, fmt_sel}, 7'h08);
        chk({left_halt, left_on, left_gain, right_halt, right_on, right_gain} == 16'h0,
            "R4 channel fields", {left_halt, left_on, left_gain}, 0);
        chk({ns_high_order, mod_full, idle_pulse} == 3'b001, "R4 misc fields",
            {ns_high_order, mod_full, idle_pulse}, 1);
        reg_read(8'h10, v); chk(v == 8'h08, "R4 read 10h", v, 8'h08);
        reg_read(8'h20, v); chk(v == 8'h00, "R4 read 20h", v, 0);
        reg_read(8'h21, v); chk(v == 8'h00, "R4 read 21h", v, 0);
        reg_read(8'h30, v); chk(v == 8'h03, "R4 read 30h", v, 8'h03);
        reg_read(8'h00, v); chk(v == 8'h30, "R5 last after read 30h", v, 8'h30);
    endtask

    task automatic t_wrong_device();
        bit ak;
        logic [7:0] v;
        bus_start();
        send_byte(8'hB4, 1'b0, ak);
        chk(ak == 1'b0, "R1 foreign address not acked", ak, 0);
        send_byte(8'h20, 1'b0, ak);
        send_byte(8'h55, 1'b0, ak);
        bus_stop();
        chk(left_gain == 6'd0 && left_on == 1'b0, "R1 no write", left_gain, 0);
        reg_read(8'h20, v); chk(v == 8'h00, "R1 read 20h unchanged", v, 0);
    endtask

    task automatic t_write_fields();
        bit ak;
        logic [7:0] v;
        reg_write(8'h10, 8'h6D, 1'b0, ak);
        chk(ak, "R2 write acked", ak, 1);
        chk(mclk_ratio == 2'b11 && srate_sel == 2'b01 && fmt_sel == 3'b101, "R2 fmt fields",
            {mclk_ratio, srate_sel, fmt_sel}, 7'h6D);
        reg_write(8'h20, 8'hC7, 1'b0, ak);
        chk(left_halt && left_on && left_gain == 6'h07, "R2 left fields",
            {left_halt, left_on, left_gain}, 8'hC7);
        reg_write(8'h21, 8'h3F, 1'b0, ak);
        chk(!right_halt && !right_on && right_gain == 6'h3F, "R2 right fields",
            {right_halt, right_on, right_gain}, 8'h3F);
        reg_write(8'h30, 8'hFE, 1'b0, ak);
        chk({ns_high_order, mod_full, idle_pulse} == 3'b111, "R2 misc fields",
            {ns_high_order, mod_full, idle_pulse}, 7);
        reg_read(8'h00, v); chk(v == 8'h30, "R5 last after write 30h", v, 8'h30);
        reg_read(8'h10, v); chk(v == 8'h6D, "R3 read 10h", v, 8'h6D);
        reg_write(8'h10, 8'hFF, 1'b0, ak);
        reg_read(8'h10, v); chk(v == 8'h7F, "R3 bit7 of 10h reads 0", v, 8'h7F);
        reg_read(8'h30, v); chk(v == 8'h0F, "R3 read 30h", v, 8'h0F);
        reg_read(8'h20, v); chk(v == 8'hC7, "R3 read 20h", v, 8'hC7);
    endtask

    task automatic t_status_reg();
        bit ak;
        logic [7:0] v;
        reg_write(8'h21, 8'h45, 1'b0, ak);
        reg_read(8'h00, v); chk(v == 8'h21, "R5 last after write 21h", v, 8'h21);
        reg_write(8'h00, 8'h55, 1'b0, ak);
        chk(ak, "R5 write to 00h acked", ak, 1);
        reg_read(8'h00, v); chk(v == 8'h00, "R5 00h not writable", v, 0);
        chk(right_gain == 6'h05 && right_on, "R5 other regs untouched", right_gain, 5);
    endtask

    task automatic t_undefined();
        bit ak;
        logic [7:0] v;
        reg_write(8'h50, 8'h44, 1'b0, ak);
        chk(ak, "R7 undefined write acked", ak, 1);
        chk(left_gain == 6'h07 && right_gain == 6'h05, "R7 no effect", left_gain, 7);
        reg_read(8'h50, v); chk(v == 8'h00, "R7 undefined read", v, 0);
    endtask

    task automatic t_soft_reset();
        bit ak;
        logic [7:0] v;
        reg_write(8'hFF, 8'h12, 1'b0, ak);
        chk(left_gain == 6'h07 && mclk_ratio == 2'b11, "R6 wrong code ignored", left_gain, 7);
        reg_write(8'hFF, 8'hFF, 1'b0, ak);
        chk(left_gain == 0 && right_gain == 0 && !left_halt && !right_on &&
            {mclk_ratio, srate_sel, fmt_sel} == 7'h08 &&
            {ns_high_order, mod_full, idle_pulse} == 3'b001, "R6 ports restored",
            {mclk_ratio, srate_sel, fmt_sel}, 8'h08);
        reg_read(8'h00, v); chk(v == 8'h00, "R6 last address cleared", v, 0);
        reg_read(8'hFF, v); chk(v == 8'h00, "R6 read FFh", v, 0);
    endtask

    task automatic t_glitch();
        bit ak;
        logic [7:0] v;
        reg_write(8'h20, 8'hA5, 1'b1, ak);
        chk(ak, "R10 write with glitch acked", ak, 1);
        reg_read(8'h20, v); chk(v == 8'hA5, "R10 glitch filtered", v, 8'hA5);
    endtask

    task automatic t_mode();
        do_reset(1'b0);
        chk(pin_only_mode == 1'b1, "R8 pin-only latched", pin_only_mode, 1);
        chk(left_gain == 0 && !left_halt, "R8 reset cleared registers", left_gain, 0);
        begin
            bit ak;
            reg_write(8'h21, 8'h41, 1'b0, ak);
            chk(pin_only_mode == 1'b1 && right_gain == 6'h01, "R8 mode held after traffic",
                pin_only_mode, 1);
        end
        do_reset(1'b1);
        chk(pin_only_mode == 1'b0, "R8 combined again", pin_only_mode, 0);
    endtask

    initial begin
        t_reset_state();
        t_wrong_device();
        t_write_fields();
        t_status_reg();
        t_undefined();
        t_soft_reset();
        t_glitch();
        t_mode();
        chk(viol == 0, "R9 sda_oe moved with SCL high", viol, 0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule